// File: doc/BRIEF.md
# Audio Serial Clock Generator

This block produces the bit clock and the left/right frame clock of a stereo serial audio link, running from the master clock. As clock provider it divides the master clock down to a bit clock and counts bit clocks into frames. As clock consumer it takes both clocks from outside, brings them into the master-clock domain and still reports where bits and frames begin. In both modes a serializer next to it gets two single-cycle strobes. `bit_stb` marks each data-launch edge of the bit clock. `frame_stb` marks the start of a left word.

A single configuration word sets everything: the provider/consumer choice, the polarity of each clock, whether the bit clock may stop while the line is idle, and the two divider ratios. Changes to this word while the clocks run are held back until the next frame boundary. The clocks run only while the transmit or the receive channel is enabled.

Top module: `audio_clk_gen`

## Requirements
- R1: In provider mode the bit clock period is 2 master-clock cycles when `cfg_word[5]` is 0 and 4 cycles when it is 1. `bit_stb` pulses once per bit clock period.
- R2: `cfg_word[7:6]` sets the frame length in bit clocks: 0 gives 32, 1 gives 64, and 2 or 3 give 128. Each frame holds exactly half its bits in the left word and half in the right word, with the left word first.
- R3: With `cfg_word[1]` clear, `bclk_o` is low in the cycle of `bit_stb` (data launches on a falling edge) and high half a period later. With it set, both levels are inverted.
- R4: With `cfg_word[0]` clear, `lrclk_o` is low for the left word and high for the right word. With it set, the levels are inverted.
- R5: `cfg_word[3]` set selects provider mode, and then `clk_oe` is 1 while the clocks run. When it is clear, `clk_oe` is 0 and the clocks come from `ext_bclk` and `ext_lrclk`.
- R6: `frame_stb` pulses for one cycle together with the `bit_stb` of the first left bit of every frame.
- R7: The clocks run while `tx_en` or `rx_en` is 1. With both at 0 there are no strobes. A provider then holds `bclk_o` and `lrclk_o` at their idle level, which is the inverse of the polarity bit (1 for polarity 0).
- R8: With `cfg_word[4]` clear, `line_idle` = 1 freezes both clocks and suppresses the strobes. With `cfg_word[4]` set, `line_idle` has no effect.
- R9: A change of `cfg_word` while the clocks run takes effect at the next frame boundary. The frame in progress finishes with the old settings.
- R10: In consumer mode the external clocks pass through a two-flop synchronizer to `bclk_o` and `lrclk_o`. `bit_stb` marks each data-launch edge of the synchronized bit clock, and `frame_stb` marks each change of the synchronized frame clock to the left word.
- R11: After reset with both channels off, `bit_stb`, `frame_stb` and `clk_oe` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_word | input | 8 | Configuration: [0] frame polarity, [1] bit polarity, [3] provider, [4] no gating, [5] bit ratio, [7:6] frame length |
| tx_en | input | 1 | Transmit channel enabled |
| rx_en | input | 1 | Receive channel enabled |
| line_idle | input | 1 | Serializer has nothing to move |
| ext_bclk | input | 1 | External bit clock (consumer mode) |
| ext_lrclk | input | 1 | External frame clock (consumer mode) |
| bclk_o | output | 1 | Bit clock |
| lrclk_o | output | 1 | Frame clock |
| clk_oe | output | 1 | Drive enable for both clocks |
| bit_stb | output | 1 | Data-launch strobe, one cycle |
| frame_stb | output | 1 | Left-word start strobe, one cycle |

## Verification
A table of six provider configurations covers both bit ratios, all four frame selects and every polarity combination. In each one the bench measures the bit period, the bits per frame, the left-word bit count and the clock levels at launch. These measurements separate a wrong divider, a wrong frame length, an unequal half split and an inverted polarity. Directed runs add four more cases. A mid-frame configuration change must leave the current frame at its old length. The gating runs contrast frozen clocks with a `line_idle` input that has no effect. The enable runs show that either channel alone starts the clocks, and a consumer run counts strobes against hand-driven external clocks.

// File: rtl/audio_clk_pkg.sv
package audio_clk_pkg;

    localparam int CFG_W           = 8;
    localparam int RATIO_LO        = 2;
    localparam int RATIO_HI        = 4;
    localparam int FRAME_MIN_BITS  = 32;
    localparam int FRAME_MAX_BITS  = 128;
    localparam int DIV_W           = $clog2(RATIO_HI);
    localparam int BIT_W           = $clog2(FRAME_MAX_BITS);

    typedef struct packed {
        logic [1:0] frame_sel;
        logic       ratio_hi;
        logic       no_gate;
        logic       provider;
        logic       pol_bit;
        logic       pol_frame;
    } clk_cfg_t;

    function automatic clk_cfg_t unpack_cfg(input logic [CFG_W-1:0] w);
        clk_cfg_t c;
        c.pol_frame = w[0];
        c.pol_bit   = w[1];
        c.provider  = w[3];
        c.no_gate   = w[4];
        c.ratio_hi  = w[5];
        c.frame_sel = w[7:6];
        return c;
    endfunction

    function automatic logic [DIV_W-1:0] div_last(input logic hi);
        return hi ? DIV_W'(RATIO_HI - 1) : DIV_W'(RATIO_LO - 1);
    endfunction

    function automatic logic [DIV_W-1:0] div_mid(input logic hi);
        return hi ? DIV_W'(RATIO_HI / 2) : DIV_W'(RATIO_LO / 2);
    endfunction

    function automatic logic [BIT_W:0] frame_len(input logic [1:0] sel);
        logic [1:0] s;
        s = (sel > 2'd2) ? 2'd2 : sel;
        return (BIT_W+1)'(FRAME_MIN_BITS) << s;
    endfunction

endpackage

// File: rtl/audio_clk_cfg_shadow.sv
module audio_clk_cfg_shadow
    import audio_clk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [CFG_W-1:0] cfg_word,
    input  logic             running,
    input  logic             boundary,
    output clk_cfg_t         act
);

    always_ff @(posedge clk) begin
        if (rst)
            act <= '0;
        else if (!running || boundary)
            act <= unpack_cfg(cfg_word);
    end

    // R9: settings stay put inside a frame
    a_r9_hold_mid_frame: assert property (@(posedge clk) disable iff (rst)
        (running && !boundary) |=> $stable(act));

endmodule

// File: rtl/audio_clk_provider.sv
module audio_clk_provider
    import audio_clk_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     run,
    input  logic     adv_ok,
    input  clk_cfg_t act,
    output logic     bclk_raw,
    output logic     lr_raw,
    output logic     bit_stb,
    output logic     frame_stb,
    output logic     boundary
);

    logic [DIV_W-1:0] div_cnt;
    logic [BIT_W-1:0] bit_cnt;
    logic [BIT_W:0]   flen;
    logic [BIT_W-1:0] bit_last;
    logic [BIT_W-1:0] bit_half;
    logic             go;
    logic             launch;

    always_comb begin
        flen     = frame_len(act.frame_sel);
        bit_last = BIT_W'(flen - 1'b1);
        bit_half = BIT_W'(flen >> 1);
        go       = run && adv_ok;
        launch   = go && (div_cnt == '0);
        boundary = launch && (bit_cnt == '0);
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            div_cnt   <= '0;
            bit_cnt   <= '0;
            bclk_raw  <= 1'b1;
            lr_raw    <= 1'b1;
            bit_stb   <= 1'b0;
            frame_stb <= 1'b0;
        end else begin
            bit_stb   <= launch;
            frame_stb <= boundary;
            if (go) begin
                div_cnt <= (div_cnt == div_last(act.ratio_hi)) ? '0 : div_cnt + 1'b1;
                if (launch) begin
                    bclk_raw <= 1'b0;
                    bit_cnt  <= (bit_cnt == bit_last) ? '0 : bit_cnt + 1'b1;
                    if (bit_cnt == '0)
                        lr_raw <= 1'b0;
                    else if (bit_cnt == bit_half)
                        lr_raw <= 1'b1;
                end else if (div_cnt == div_mid(act.ratio_hi)) begin
                    bclk_raw <= 1'b1;
                end
            end
        end
    end

    // R6: a frame strobe always rides on a bit strobe
    a_r6_frame_on_bit: assert property (@(posedge clk) disable iff (rst)
        frame_stb |-> bit_stb);

    // R1: bit period is at least two master cycles
    a_r1_no_back_to_back: assert property (@(posedge clk) disable iff (rst)
        bit_stb |=> !bit_stb);

    // R8: gated clocks hold still
    a_r8_freeze: assert property (@(posedge clk) disable iff (rst)
        (run && !adv_ok) |=> ($stable(bclk_raw) && $stable(lr_raw) && !bit_stb));

    // R7: stopped clocks sit at idle level
    a_r7_idle_level: assert property (@(posedge clk) disable iff (rst)
        !run |=> (bclk_raw && lr_raw && !bit_stb && !frame_stb));

endmodule

// File: rtl/audio_clk_consumer.sv
module audio_clk_consumer
    import audio_clk_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic ext_bclk,
    input  logic ext_lr,
    input  logic pol_bit,
    input  logic pol_frame,
    output logic bclk_s,
    output logic lr_s,
    output logic bit_stb,
    output logic frame_stb,
    output logic boundary
);

    localparam int SYNC_N = 3;

    logic [SYNC_N-1:0] b_pipe;
    logic [SYNC_N-1:0] l_pipe;
    logic              b_fall;

    always_ff @(posedge clk) begin
        if (rst) begin
            b_pipe <= '0;
            l_pipe <= '0;
        end else begin
            b_pipe <= {b_pipe[SYNC_N-2:0], ext_bclk};
            l_pipe <= {l_pipe[SYNC_N-2:0], ext_lr};
        end
    end

    always_comb begin
        bclk_s   = b_pipe[1];
        lr_s     = l_pipe[1];
        b_fall   = run && (b_pipe[2] ^ pol_bit) && !(b_pipe[1] ^ pol_bit);
        boundary = run && (l_pipe[2] ^ pol_frame) && !(l_pipe[1] ^ pol_frame);
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            bit_stb   <= 1'b0;
            frame_stb <= 1'b0;
        end else begin
            bit_stb   <= b_fall;
            frame_stb <= boundary;
        end
    end

    // R10: a launch edge needs a full bit clock cycle in between
    a_r10_bit_gap: assert property (@(posedge clk) disable iff (rst)
        bit_stb |=> !bit_stb);

    // R7: nothing is reported while stopped
    a_r7_consumer_quiet: assert property (@(posedge clk) disable iff (rst)
        !run |=> (!bit_stb && !frame_stb));

endmodule

// File: rtl/audio_clk_gen.sv
module audio_clk_gen
    import audio_clk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [CFG_W-1:0] cfg_word,
    input  logic             tx_en,
    input  logic             rx_en,
    input  logic             line_idle,
    input  logic             ext_bclk,
    input  logic             ext_lrclk,
    output logic             bclk_o,
    output logic             lrclk_o,
    output logic             clk_oe,
    output logic             bit_stb,
    output logic             frame_stb
);

    clk_cfg_t act;
    logic     run;
    logic     p_run, c_run;
    logic     p_bclk, p_lr, p_bit, p_frame, p_bound;
    logic     c_bclk, c_lr, c_bit, c_frame, c_bound;
    logic     boundary;

    always_comb begin
        run      = tx_en || rx_en;
        p_run    = run && act.provider;
        c_run    = run && !act.provider;
        boundary = act.provider ? p_bound : c_bound;
    end

    audio_clk_cfg_shadow u_shadow (
        .clk      (clk),
        .rst      (rst),
        .cfg_word (cfg_word),
        .running  (run),
        .boundary (boundary),
        .act      (act)
    );

    audio_clk_provider u_prov (
        .clk       (clk),
        .rst       (rst),
        .run       (p_run),
        .adv_ok    (act.no_gate || !line_idle),
        .act       (act),
        .bclk_raw  (p_bclk),
        .lr_raw    (p_lr),
        .bit_stb   (p_bit),
        .frame_stb (p_frame),
        .boundary  (p_bound)
    );

    audio_clk_consumer u_cons (
        .clk       (clk),
        .rst       (rst),
        .run       (c_run),
        .ext_bclk  (ext_bclk),
        .ext_lr    (ext_lrclk),
        .pol_bit   (act.pol_bit),
        .pol_frame (act.pol_frame),
        .bclk_s    (c_bclk),
        .lr_s      (c_lr),
        .bit_stb   (c_bit),
        .frame_stb (c_frame),
        .boundary  (c_bound)
    );

    always_comb begin
        if (act.provider) begin
            bclk_o    = p_bclk ^ act.pol_bit;
            lrclk_o   = p_lr ^ act.pol_frame;
            bit_stb   = p_bit;
            frame_stb = p_frame;
        end else begin
            bclk_o    = c_bclk;
            lrclk_o   = c_lr;
            bit_stb   = c_bit;
            frame_stb = c_frame;
        end
        clk_oe = p_run;
    end

    // R5: consumer mode never drives the clock pins
    a_r5_consumer_no_drive: assert property (@(posedge clk) disable iff (rst)
        !act.provider |-> !clk_oe);

    // R11: reset leaves the strobes quiet
    a_r11_reset_quiet: assert property (@(posedge clk)
        $past(rst) |-> (!bit_stb && !frame_stb));

endmodule

// File: tb/audio_clk_gen_tb_top.sv
module audio_clk_gen_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 6;
    localparam int WATCHDOG   = 150000;

    localparam logic [7:0] V_CFG [NVEC] = '{8'h18, 8'h78, 8'h98, 8'h3B, 8'hD9, 8'h5A};
    localparam int         V_PER [NVEC] = '{2, 4, 2, 4, 2, 2};
    localparam int         V_FB  [NVEC] = '{32, 64, 128, 32, 128, 64};

    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] cfg_word;
    logic       tx_en, rx_en, line_idle, ext_bclk, ext_lrclk;
    logic       bclk_o, lrclk_o, clk_oe, bit_stb, frame_stb;

    int errors = 0;
    int checks = 0;
    int bit_total = 0;
    int frame_total = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        bit_total   <= bit_total + int'(bit_stb);
        frame_total <= frame_total + int'(frame_stb);
    end

    audio_clk_gen dut_i (
        .clk       (clk),
        .rst       (rst),
        .cfg_word  (cfg_word),
        .tx_en     (tx_en),
        .rx_en     (rx_en),
        .line_idle (line_idle),
        .ext_bclk  (ext_bclk),
        .ext_lrclk (ext_lrclk),
        .bclk_o    (bclk_o),
        .lrclk_o   (lrclk_o),
        .clk_oe    (clk_oe),
        .bit_stb   (bit_stb),
        .frame_stb (frame_stb)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic stop_and_set(input logic [7:0] c);
        @(negedge clk);
        tx_en = 1'b0;
        rx_en = 1'b0;
        repeat (2) @(negedge clk);
        cfg_word = c;
        repeat (2) @(negedge clk);
    endtask

    task automatic measure(input int per, input int fb, input logic pb, input logic pf);
        int c;
        int bits;
        int left;
        logic mid;
        do @(negedge clk); while (!frame_stb);
        check(lrclk_o == pf, "R4 left level", lrclk_o, pf);
        check(bclk_o == pb, "R3 launch level", bclk_o, pb);
        check(bit_stb == 1'b1, "R6 frame with bit", bit_stb, 1);
        c = 0;
        mid = pb;
        do begin
            @(negedge clk);
            c++;
            if (c == per / 2) mid = bclk_o;
        end while (!bit_stb);
        check(c == per, "R1 bit period", c, per);
        check(mid == !pb, "R3 mid-bit level", mid, !pb);
        bits = 2;
        left = 1 + int'(lrclk_o == pf);
        forever begin
            @(negedge clk);
            if (frame_stb) break;
            if (bit_stb) begin
                bits++;
                left += int'(lrclk_o == pf);
            end
        end
        check(bits == fb, "R2 frame length", bits, fb);
        check(left == fb / 2, "R2 left half", left, fb / 2);
    endtask

    task automatic window(input int n, output int nb, output int nf);
        int b0;
        int f0;
        b0 = bit_total;
        f0 = frame_total;
        repeat (n) @(negedge clk);
        #1;
        nb = bit_total - b0;
        nf = frame_total - f0;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", WATCHDOG, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int nb;
        int nf;
        int bits;
        logic held;
        rst = 1'b1;
        cfg_word = 8'h18;
        tx_en = 1'b0;
        rx_en = 1'b0;
        line_idle = 1'b0;
        ext_bclk = 1'b1;
        ext_lrclk = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        // R11 reset state
        check(bit_stb == 1'b0, "R11 bit_stb", bit_stb, 0);
        check(frame_stb == 1'b0, "R11 frame_stb", frame_stb, 0);
        check(clk_oe == 1'b0, "R11 clk_oe", clk_oe, 0);
        check(bclk_o == 1'b1, "R7 idle bclk", bclk_o, 1);
        check(lrclk_o == 1'b1, "R7 idle lrclk", lrclk_o, 1);

        // Table of provider configurations: R1 R2 R3 R4 R5 R6
        for (int i = 0; i < NVEC; i++) begin
            stop_and_set(V_CFG[i]);
            tx_en = 1'b1;
            measure(V_PER[i], V_FB[i], V_CFG[i][1], V_CFG[i][0]);
            check(clk_oe == 1'b1, "R5 provider drives", clk_oe, 1);
        end

        // R7: both channels off, idle levels with inverted polarity
        stop_and_set(8'h1B);
        window(40, nb, nf);
        check(nb == 0, "R7 no strobes when off", nb, 0);
        check(bclk_o == 1'b0, "R7 idle bclk inverted", bclk_o, 0);
        check(lrclk_o == 1'b0, "R7 idle lrclk inverted", lrclk_o, 0);
        // R7: receive channel alone starts the clocks
        stop_and_set(8'h18);
        rx_en = 1'b1;
        window(40, nb, nf);
        check(nb == 20, "R7 rx alone runs", nb, 20);

        // R9: change mid-frame keeps the current frame
        stop_and_set(8'h18);
        tx_en = 1'b1;
        do @(negedge clk); while (!frame_stb);
        bits = 1;
        forever begin
            @(negedge clk);
            if (frame_stb) break;
            if (bit_stb) begin
                bits++;
                if (bits == 4) cfg_word = 8'h78;
            end
        end
        check(bits == 32, "R9 old frame completes", bits, 32);
        measure(4, 64, 1'b0, 1'b0);

        // R8: gating allowed and line idle freezes everything
        stop_and_set(8'h08);
        line_idle = 1'b1;
        tx_en = 1'b1;
        window(40, nb, nf);
        check(nb == 0, "R8 gated no strobes", nb, 0);
        check(bclk_o == 1'b1, "R8 gated bclk held", bclk_o, 1);
        check(clk_oe == 1'b1, "R8 provider still drives", clk_oe, 1);
        line_idle = 1'b0;
        window(40, nb, nf);
        check(nb == 20, "R8 ungated runs", nb, 20);
        @(negedge clk);
        line_idle = 1'b1;
        @(negedge clk);
        held = bclk_o;
        window(10, nb, nf);
        check(nb == 0, "R8 mid-run freeze strobes", nb, 0);
        check(bclk_o == held, "R8 mid-run freeze level", bclk_o, held);
        // R8: with no-gating set, line_idle has no effect
        stop_and_set(8'h18);
        line_idle = 1'b1;
        tx_en = 1'b1;
        window(40, nb, nf);
        check(nb == 20, "R8 line_idle ignored", nb, 20);
        line_idle = 1'b0;

        // R10: consumer mode with external clocks
        stop_and_set(8'h00);
        ext_bclk = 1'b1;
        ext_lrclk = 1'b1;
        tx_en = 1'b1;
        repeat (4) @(negedge clk);
        begin
            int b0;
            int f0;
            b0 = bit_total;
            f0 = frame_total;
            for (int p = 0; p < 16; p++) begin
                ext_bclk = 1'b0;
                if (p == 0) ext_lrclk = 1'b0;
                if (p == 8) ext_lrclk = 1'b1;
                repeat (3) @(negedge clk);
                if (p == 0) check(bclk_o == 1'b0, "R10 bclk follows", bclk_o, 0);
                ext_bclk = 1'b1;
                repeat (3) @(negedge clk);
                if (p == 0) check(bclk_o == 1'b1, "R10 bclk follows high", bclk_o, 1);
            end
            repeat (6) @(negedge clk);
            #1;
            check(bit_total - b0 == 16, "R10 consumer bit strobes", bit_total - b0, 16);
            check(frame_total - f0 == 1, "R10 consumer frame strobes", frame_total - f0, 1);
            check(clk_oe == 1'b0, "R5 consumer no drive", clk_oe, 0);
            check(lrclk_o == 1'b1, "R10 lrclk follows", lrclk_o, 1);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule